// File: doc/BRIEF.md
# Duty-Cycle Programmable Clock Divider

This block is the output stage of a clock synthesizer. It divides a source clock by an integer N and sets the high and low times of the result separately, so the duty cycle of the divided clock can be chosen in fine steps. The block runs on a fast timing clock `clk` whose every cycle stands for one half-period of the source clock. Every length the block produces is therefore a whole number of half-periods. A divide-by-N output lasts 2N cycles of `clk`.

The configuration is a whole-period high count `cfg_hi`, a whole-period low count `cfg_lo` and a half-step bit `cfg_half`. The half-step bit moves one half-period from the low phase to the high phase. N equals `cfg_hi + cfg_lo`. At each low-to-high transition of the output, a new setting is checked. A setting that is not legal is refused, and the last accepted setting stays in force. When `fb_mode` is high, the output is taken to be driving a feedback path, and only an exact 50% setting is accepted.

Top module: `dcdiv_top`

## Requirements
- R1: While `rst_n` is low, `clk_out` is low. The first `clk` edge after release samples the configuration. `clk_out` then stays low for the low length of that sampled setting, counted in `clk` cycles from that edge, and then rises.
- R2: Each high phase of `clk_out` lasts exactly 2*`cfg_hi` + `cfg_half` cycles of `clk`, using the accepted setting.
- R3: Each low phase lasts exactly 2*`cfg_lo` - `cfg_half` cycles of `clk`, so the period is 2N cycles with N = `cfg_hi` + `cfg_lo`.
- R4: Setting `cfg_half` to 1 moves exactly one cycle from the low phase to the high phase and leaves the period unchanged. The duty cycle therefore steps by 50%/N; with N = 10 the step is 5%.
- R5: The extreme settings are accepted. `cfg_hi`=0 with `cfg_half`=1 gives a one-cycle high phase (5% at N = 10). `cfg_lo`=1 with `cfg_half`=1 gives a one-cycle low phase.
- R6: A setting with `cfg_hi`=0 and `cfg_half`=0 (zero high time) is refused, and the previous high and low lengths continue.
- R7: A setting with `cfg_lo`=0 (high time of 2N half-periods or more) is refused, and the previous lengths continue.
- R8: A new setting takes effect only at a low-to-high transition of `clk_out`. A change applied during a period does not alter that period's remaining high or low time.
- R9: While `fb_mode` is 1, a setting is accepted only if `cfg_hi` equals `cfg_lo` and `cfg_half` is 0. Any other setting is refused and the previous lengths continue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timing clock, one cycle per source half-period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hi | input | CW | High time in whole source periods |
| cfg_lo | input | CW | Low time in whole source periods |
| cfg_half | input | 1 | Moves one half-period from low time to high time |
| fb_mode | input | 1 | Feedback duty: accept only exact 50% settings |
| clk_out | output | 1 | Divided output waveform |

## Verification
The hardest case to reach is a setting change that arrives inside a running period. It must leave that period's remaining high and low time intact and take hold only at the next rising edge. The stimulus gets there by waiting until the bench samples the output's first high cycle. It then swaps in a very different setting at that same falling edge and measures the rest of the period, which must still match the old lengths. It then measures the following period, which must match the new ones. The refusal cases are driven the same way: a known legal setting is proven first, then an illegal one is presented and the measured lengths must still match the proven ones.

// File: rtl/dcdiv_pkg.sv
package dcdiv_pkg;

   // Output phase of the divider
   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // Smallest count width the block supports
   localparam int unsigned CW_MIN = 2;

endpackage

// File: rtl/dcdiv_cfg_gate.sv
// Validates a requested setting and holds the accepted half-period lengths.
module dcdiv_cfg_gate #(
   parameter int unsigned CW          = 8,
   parameter int unsigned DEF_HI      = 1,
   parameter int unsigned DEF_LO      = 1,
   parameter bit          DEF_HALF    = 1'b0,
   parameter bit          FB_CHECK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] cfg_hi,
   input  logic [CW-1:0] cfg_lo,
   input  logic          cfg_half,
   input  logic          fb_mode,
   output logic [CW:0]   nxt_hi_len,
   output logic [CW:0]   nxt_lo_len,
   output logic [CW:0]   act_hi_len,
   output logic [CW:0]   act_lo_len
);
   localparam int unsigned LW = CW + 1;
   localparam logic [LW-1:0] RST_HI_LEN = LW'(2 * DEF_HI + 32'(DEF_HALF));
   localparam logic [LW-1:0] RST_LO_LEN = LW'(2 * DEF_LO - 32'(DEF_HALF));

   logic [LW-1:0] req_hi_len;
   logic [LW-1:0] req_lo_len;
   logic          shape_ok;
   logic          fb_ok;
   logic          accept;

   // Lengths in half-periods: high = 2*hi + half, low = 2*lo - half
   assign req_hi_len = {cfg_hi, cfg_half};
   assign req_lo_len = {cfg_lo, 1'b0} - {{CW{1'b0}}, cfg_half};

   // Zero high time and a high time of 2N or more are both refused
   assign shape_ok = (req_hi_len != '0) && (cfg_lo != '0);

   generate
      if (FB_CHECK_EN) begin : g_fb_check
         assign fb_ok = !fb_mode || (!cfg_half && (cfg_hi == cfg_lo));
      end else begin : g_fb_free
         assign fb_ok = 1'b1;
      end
   endgenerate

   assign accept     = shape_ok && fb_ok;
   assign nxt_hi_len = accept ? req_hi_len : act_hi_len;
   assign nxt_lo_len = accept ? req_lo_len : act_lo_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_hi_len <= RST_HI_LEN;
         act_lo_len <= RST_LO_LEN;
      end else if (load) begin
         act_hi_len <= nxt_hi_len;
         act_lo_len <= nxt_lo_len;
      end
   end

endmodule

// File: rtl/dcdiv_phase_cnt.sv
// Half-period down-counter that times each phase of the output.
module dcdiv_phase_cnt #(
   parameter int unsigned CW = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [CW:0] nxt_hi_len,
   input  logic [CW:0] nxt_lo_len,
   input  logic [CW:0] act_lo_len,
   output logic        load,
   output logic        armed,
   output logic        clk_out
);
   import dcdiv_pkg::*;

   localparam int unsigned LW = CW + 1;
   localparam logic [LW-1:0] ONE = LW'(1);

   phase_e        phase;
   logic [LW-1:0] cnt;
   logic          at_end;

   assign at_end  = (cnt == '0);
   // Setting is sampled on the arming edge and at every rising transition
   assign load    = !armed || (at_end && (phase == PH_LOW));
   assign clk_out = (phase == PH_HIGH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         phase <= PH_LOW;
         cnt   <= '0;
      end else if (!armed) begin
         armed <= 1'b1;
         cnt   <= nxt_lo_len - ONE;
      end else if (at_end) begin
         if (phase == PH_LOW) begin
            phase <= PH_HIGH;
            cnt   <= nxt_hi_len - ONE;
         end else begin
            phase <= PH_LOW;
            cnt   <= act_lo_len - ONE;
         end
      end else begin
         cnt <= cnt - ONE;
      end
   end

endmodule

// File: rtl/dcdiv_top.sv
// Post-scale divider with separately programmed high and low times.
module dcdiv_top #(
   parameter int unsigned CW          = 8,
   parameter int unsigned DEF_HI      = 1,
   parameter int unsigned DEF_LO      = 1,
   parameter bit          DEF_HALF    = 1'b0,
   parameter bit          FB_CHECK_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_hi,
   input  logic [CW-1:0] cfg_lo,
   input  logic          cfg_half,
   input  logic          fb_mode,
   output logic          clk_out
);
   localparam int unsigned LW = CW + 1;

   generate
      if (CW < dcdiv_pkg::CW_MIN) begin : g_bad_cw
         $error("dcdiv_top: CW must be at least %0d", dcdiv_pkg::CW_MIN);
      end
      if ((DEF_HI == 0 && !DEF_HALF) || DEF_LO == 0) begin : g_bad_def
         $error("dcdiv_top: reset setting must have nonzero high and low time");
      end
      if (DEF_HI >= (1 << CW) || DEF_LO >= (1 << CW)) begin : g_bad_def_w
         $error("dcdiv_top: reset counts do not fit in CW bits");
      end
   endgenerate

   logic          load;
   logic          armed;
   logic [LW-1:0] nxt_hi_len;
   logic [LW-1:0] nxt_lo_len;
   logic [LW-1:0] act_hi_len;
   logic [LW-1:0] act_lo_len;

   dcdiv_cfg_gate #(
      .CW          (CW),
      .DEF_HI      (DEF_HI),
      .DEF_LO      (DEF_LO),
      .DEF_HALF    (DEF_HALF),
      .FB_CHECK_EN (FB_CHECK_EN)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .cfg_hi     (cfg_hi),
      .cfg_lo     (cfg_lo),
      .cfg_half   (cfg_half),
      .fb_mode    (fb_mode),
      .nxt_hi_len (nxt_hi_len),
      .nxt_lo_len (nxt_lo_len),
      .act_hi_len (act_hi_len),
      .act_lo_len (act_lo_len)
   );

   dcdiv_phase_cnt #(
      .CW (CW)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .nxt_hi_len (nxt_hi_len),
      .nxt_lo_len (nxt_lo_len),
      .act_lo_len (act_lo_len),
      .load       (load),
      .armed      (armed),
      .clk_out    (clk_out)
   );

endmodule

// File: rtl/dcdiv_chk.sv
// Property checker for dcdiv_top, attached through bind below.
module dcdiv_chk #(
   parameter int unsigned CW          = 8,
   parameter bit          FB_CHECK_EN = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        clk_out,
   input logic        armed,
   input logic        fb_mode,
   input logic        load,
   input logic [CW:0] act_hi_len,
   input logic [CW:0] act_lo_len
);
   localparam int unsigned RW = CW + 2;

   logic [RW-1:0] run_q;
   logic          last_q;
   logic          seen_fall;

   // Length of the current run of equal clk_out samples
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= '0;
         last_q    <= 1'b0;
         seen_fall <= 1'b0;
      end else begin
         last_q <= clk_out;
         if (clk_out != last_q) begin
            run_q <= RW'(1);
         end else if (run_q != '1) begin
            run_q <= run_q + RW'(1);
         end
         if (last_q && !clk_out) begin
            seen_fall <= 1'b1;
         end
      end
   end

   AST_RESET_LOW: assert property (@(posedge clk) !armed |-> !clk_out); // R1

   AST_HIGH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (last_q && !clk_out) |-> (run_q == RW'(act_hi_len))); // R2

   AST_LOW_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (!last_q && clk_out && seen_fall) |-> (run_q == RW'($past(act_lo_len)))); // R3

   AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (act_hi_len != '0) && (act_lo_len != '0)); // R6

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(armed) && !$rose(clk_out))
         |-> ($stable(act_hi_len) && $stable(act_lo_len))); // R8

   AST_LOAD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && load) |=> clk_out); // R8

   AST_FB_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      ((FB_CHECK_EN != 1'b0) && $rose(clk_out) && $past(fb_mode) && $past(armed)
         && !$stable(act_hi_len)) |-> (act_hi_len == act_lo_len)); // R9

endmodule

bind dcdiv_top dcdiv_chk #(
   .CW          (CW),
   .FB_CHECK_EN (FB_CHECK_EN)
) u_dcdiv_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clk_out    (clk_out),
   .armed      (armed),
   .fb_mode    (fb_mode),
   .load       (load),
   .act_hi_len (act_hi_len),
   .act_lo_len (act_lo_len)
);

// File: tb/tb_dcdiv_top.sv
module tb_dcdiv_top;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_hi = '0;
   logic [CW-1:0] cfg_lo = '0;
   logic          cfg_half = 1'b0;
   logic          fb_mode = 1'b0;
   logic          clk_out;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dcdiv_top #(.CW(CW)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_hi   (cfg_hi),
      .cfg_lo   (cfg_lo),
      .cfg_half (cfg_half),
      .fb_mode  (fb_mode),
      .clk_out  (clk_out)
   );

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   task automatic set_cfg(input int hi, input int lo, input bit half, input bit fb);
      cfg_hi   = CW'(hi);
      cfg_lo   = CW'(lo);
      cfg_half = half;
      fb_mode  = fb;
   endtask

   // Counts the rest of a period whose first high sample was just taken
   task automatic count_rest(output int h, output int l);
      h = 1;
      @(negedge clk);
      while (clk_out) begin h++; @(negedge clk); end
      l = 1;
      @(negedge clk);
      while (!clk_out) begin l++; @(negedge clk); end
   endtask

   // Measures one full period starting at the next rising transition
   task automatic measure(output int h, output int l);
      do @(negedge clk); while (clk_out);
      do @(negedge clk); while (!clk_out);
      count_rest(h, l);
   endtask

   task automatic run_shape(input string tag, input int hi, input int lo, input bit half,
                            input bit fb, input int exp_h, input int exp_l);
      int h, l;
      set_cfg(hi, lo, half, fb);
      measure(h, l);
      check({tag, " high"}, h, exp_h);
      check({tag, " low"}, l, exp_l);
   endtask

   task automatic t_reset();
      int lo_cnt, h, l;
      set_cfg(3, 4, 1'b0, 1'b0);
      repeat (3) @(negedge clk);
      check("R1 output low in reset", int'(clk_out), 0);
      rst_n = 1'b1;
      lo_cnt = 0;
      @(negedge clk);
      while (!clk_out) begin lo_cnt++; @(negedge clk); end
      check("R1 first low time", lo_cnt, 8);
      count_rest(h, l);
      check("R1 first high time", h, 6);
      check("R1 second low time", l, 8);
   endtask

   task automatic t_shapes();
      run_shape("R2 R3 N=10 50%", 5, 5, 1'b0, 1'b0, 10, 10);
      run_shape("R2 R3 N=3", 1, 2, 1'b0, 1'b0, 2, 4);
      run_shape("R2 R3 N=10 70%", 7, 3, 1'b0, 1'b0, 14, 6);
   endtask

   task automatic t_half_step();
      run_shape("R4 N=10 40%", 4, 6, 1'b0, 1'b0, 8, 12);
      run_shape("R4 N=10 45%", 4, 6, 1'b1, 1'b0, 9, 11);
   endtask

   task automatic t_extremes();
      run_shape("R5 N=10 5%", 0, 10, 1'b1, 1'b0, 1, 19);
      run_shape("R5 N=10 95%", 9, 1, 1'b1, 1'b0, 19, 1);
   endtask

   task automatic t_reject_zero_high();
      run_shape("R6 setup", 2, 3, 1'b0, 1'b0, 4, 6);
      run_shape("R6 zero high refused", 0, 7, 1'b0, 1'b0, 4, 6);
   endtask

   task automatic t_reject_zero_low();
      run_shape("R7 setup", 3, 2, 1'b0, 1'b0, 6, 4);
      run_shape("R7 zero low refused", 6, 0, 1'b1, 1'b0, 6, 4);
      run_shape("R7 zero low no half refused", 5, 0, 1'b0, 1'b0, 6, 4);
   endtask

   task automatic t_boundary();
      int h, l;
      run_shape("R8 setup", 2, 3, 1'b0, 1'b0, 4, 6);
      // measure ended on the first high sample of a new period: change now
      set_cfg(6, 2, 1'b1, 1'b0);
      count_rest(h, l);
      check("R8 running period high kept", h, 4);
      check("R8 running period low kept", l, 6);
      // count_rest ended on the next rise, which took the new setting
      count_rest(h, l);
      check("R8 next period high new", h, 13);
      check("R8 next period low new", l, 3);
   endtask

   task automatic t_feedback();
      run_shape("R9 setup", 2, 5, 1'b1, 1'b0, 5, 9);
      run_shape("R9 unequal refused", 3, 5, 1'b0, 1'b1, 5, 9);
      run_shape("R9 half step refused", 4, 4, 1'b1, 1'b1, 5, 9);
      run_shape("R9 exact 50% accepted", 4, 4, 1'b0, 1'b1, 8, 8);
      run_shape("R9 released", 1, 4, 1'b1, 1'b0, 3, 7);
   endtask

   initial begin
      t_reset();
      t_shapes();
      t_half_step();
      t_extremes();
      t_reject_zero_high();
      t_reject_zero_low();
      t_boundary();
      t_feedback();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule